// File: doc/BRIEF.md
# Programmable Word-Wide CRC Engine

This block keeps a running 32-bit cyclic redundancy check behind a small memory-mapped register file. Software programs a seed and a generator polynomial, writes the control register with its reload bit set, and then writes the message one 32-bit word at a time into the data register. Each write folds the whole word into the accumulator in a single clock. Reading the same data register returns the current checksum, so a partial result is available at any point in a stream.

Two bit-order options cover both conventions. The input option mirrors each incoming word end to end before it is folded. The output option mirrors the accumulator on its way to the read port. With both options on, and with the seed and polynomial loaded in mirrored form, the engine yields the common LSB-first checksums, such as CRC-32 (reflected constant 0xEDB88320) and CRC-32C (reflected constant 0x82F63B78). The engine applies no final XOR. A consumer that needs a final complement, as CRC-32C does, applies it itself.

The bus is a single-cycle register port. A write takes effect at the clock edge where `bus_valid` and `bus_we` are both high. Read data is combinational from the current state whenever `bus_valid` is high and `bus_we` is low.

Top module: `crcw_engine`

## Requirements
- R1: Registers are selected by word address. Data is at 0 (byte offset 0x00), control at 2 (0x08), seed at 4 (0x10) and polynomial at 5 (0x14). Writes to any other address change nothing. Reads of any other address, and any cycle without a read, return 0.
- R2: After synchronous reset the seed reads 0xFFFFFFFF, the polynomial reads 0x04C11DB7, control reads 0, and the data register reads 0xFFFFFFFF.
- R3: Writing control with bit 0 set loads the accumulator from the current seed register. Bit 0 never stores and always reads back as 0.
- R4: A control write stores bits 7:5 as the mode. A control read returns the stored mode in bits 7:5 and zeros in every other bit.
- R5: A data write XORs the word, after any input mirroring, into the accumulator. It then applies 32 MSB-first steps: shift left by one, and XOR the polynomial in whenever the bit shifted out was 1.
- R6: The input word is mirrored (bit i goes to bit 31-i) only when control bits 6:5 are both 1. The values 00, 01 and 10 leave the word as written.
- R7: With control bit 7 set, a read of the data register returns the accumulator mirrored. With bit 7 clear, the read returns the accumulator unchanged.
- R8: With control bits 7:5 = 111, the seed set to the mirror of the reflected starting value, and the polynomial set to the mirror of 0xEDB88320 or 0x82F63B78, the data register holds the standard LSB-first CRC-32 or CRC-32C (without final XOR) of the little-endian words written.
- R9: A data read in the cycle after a reload returns the seed, or its mirror when bit 7 is set.
- R10: Data writes on consecutive cycles are each folded, with no stall. Reads never change the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Word address of the register |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data, combinational |

## Verification
The hardest case to reach from the ports is agreement between the MSB-first hardware fold and the LSB-first checksum convention. Agreement depends on the mirrored seed and polynomial, the input mirroring and the output mirroring all acting together. A slip in any one of them can leave the other modes correct. The bench drives the mirrored standard constants and compares the data register against an independent LSB-first bit-serial model for both polynomials. It also sweeps all eight mode values against an MSB-first serial model, using word streams of several lengths and random seeds. A back-to-back burst confirms that no word is dropped when writes arrive on consecutive cycles.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

    // Register word addresses; the fold order of control bits matters
    localparam logic [2:0] SEL_DATA = 3'd0;
    localparam logic [2:0] SEL_CTRL = 3'd2;
    localparam logic [2:0] SEL_SEED = 3'd4;
    localparam logic [2:0] SEL_POLY = 3'd5;

    localparam int RELOAD_BIT = 0;
    localparam int MODE_LSB   = 5;
    localparam int MODE_W     = 3;

    localparam logic [31:0] SEED_AT_RESET = 32'hFFFF_FFFF;
    localparam logic [31:0] POLY_AT_RESET = 32'h04C1_1DB7;

    // Mode field as stored: bit 7 output mirror, bits 6:5 input mirror
    typedef struct packed {
        logic       out_flip;
        logic [1:0] in_flip;
    } mode_t;

    function automatic logic in_mirror_on(input mode_t m);
        return m.in_flip == 2'b11;
    endfunction

endpackage

// File: rtl/crcw_bitrev.sv
module crcw_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_swap
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/crcw_fold.sv
module crcw_fold #(
    parameter int W = 32
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] word,
    input  logic [W-1:0] poly,
    output logic [W-1:0] crc_out
);
    localparam int STEPS = W;

    logic [W-1:0] stage [STEPS+1];

    assign stage[0] = crc_in ^ word;

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        assign stage[s+1] = stage[s][W-1] ? ((stage[s] << 1) ^ poly)
                                          : (stage[s] << 1);
    end

    assign crc_out = stage[STEPS];
endmodule

// File: rtl/crcw_engine.sv
module crcw_engine
    import crcw_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata
);
    localparam int CTRL_USED = MODE_LSB + MODE_W;

    logic [W-1:0] acc_q, seed_q, poly_q;
    mode_t        mode_q;

    logic         wr, rd;
    logic         wr_data, wr_ctrl, wr_seed, wr_poly;
    logic [W-1:0] word_fwd, word_rev, word_sel, acc_next, acc_rev, acc_view;

    assign wr      = bus_valid && bus_we;
    assign rd      = bus_valid && !bus_we;
    assign wr_data = wr && (bus_addr == ADDR_W'(SEL_DATA));
    assign wr_ctrl = wr && (bus_addr == ADDR_W'(SEL_CTRL));
    assign wr_seed = wr && (bus_addr == ADDR_W'(SEL_SEED));
    assign wr_poly = wr && (bus_addr == ADDR_W'(SEL_POLY));

    assign word_fwd = bus_wdata;

    crcw_bitrev #(.W(W)) u_in_rev  (.din(word_fwd), .dout(word_rev));
    crcw_bitrev #(.W(W)) u_out_rev (.din(acc_q),    .dout(acc_rev));

    assign word_sel = in_mirror_on(mode_q) ? word_rev : word_fwd;

    crcw_fold #(.W(W)) u_fold (
        .crc_in (acc_q),
        .word   (word_sel),
        .poly   (poly_q),
        .crc_out(acc_next)
    );

    assign acc_view = mode_q.out_flip ? acc_rev : acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q <= W'(SEED_AT_RESET);
            poly_q <= W'(POLY_AT_RESET);
            mode_q <= '0;
            acc_q  <= W'(SEED_AT_RESET);
        end else begin
            if (wr_seed) seed_q <= bus_wdata;
            if (wr_poly) poly_q <= bus_wdata;
            if (wr_ctrl) mode_q <= mode_t'(bus_wdata[MODE_LSB +: MODE_W]);
            if (wr_ctrl && bus_wdata[RELOAD_BIT]) acc_q <= seed_q;
            else if (wr_data)                     acc_q <= acc_next;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                ADDR_W'(SEL_DATA): bus_rdata = acc_view;
                ADDR_W'(SEL_CTRL): bus_rdata = W'({mode_q, {MODE_LSB{1'b0}}});
                ADDR_W'(SEL_SEED): bus_rdata = seed_q;
                ADDR_W'(SEL_POLY): bus_rdata = poly_q;
                default:           bus_rdata = '0;
            endcase
        end
    end

    initial begin
        if (CTRL_USED > W) $error("control field wider than data path");
    end
endmodule

// File: rtl/crcw_checker.sv
module crcw_checker
    import crcw_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      acc_q,
    input logic [W-1:0]      seed_q,
    input logic              out_flip
);
    logic is_rd, is_data, reload_ev, fold_ev, rd_data, mapped;

    assign is_rd     = bus_valid && !bus_we;
    assign is_data   = bus_addr == ADDR_W'(SEL_DATA);
    assign rd_data   = is_rd && is_data;
    assign reload_ev = !rst && bus_valid && bus_we &&
                       (bus_addr == ADDR_W'(SEL_CTRL)) && bus_wdata[RELOAD_BIT];
    assign fold_ev   = bus_valid && bus_we && is_data;
    assign mapped    = is_data || bus_addr == ADDR_W'(SEL_CTRL) ||
                       bus_addr == ADDR_W'(SEL_SEED) || bus_addr == ADDR_W'(SEL_POLY);

    // R1
    a_r1_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> bus_rdata == '0);

    // R1
    a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (is_rd && !mapped) |-> bus_rdata == '0);

    // R3 / R4
    a_r3_ctrl_readback_shape: assert property (@(posedge clk) disable iff (rst)
        (is_rd && bus_addr == ADDR_W'(SEL_CTRL)) |->
        (bus_rdata[RELOAD_BIT] == 1'b0 && bus_rdata[MODE_LSB-1:0] == '0));

    // R9
    a_r9_reload_then_read: assert property (@(posedge clk) disable iff (rst)
        reload_ev |=> (rd_data && !out_flip) |-> bus_rdata == $past(seed_q));

    // R10
    a_r10_acc_held: assert property (@(posedge clk) disable iff (rst)
        (!reload_ev && !fold_ev) |=> $stable(acc_q));
endmodule

bind crcw_engine crcw_checker #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_valid(bus_valid),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .acc_q    (acc_q),
    .seed_q   (seed_q),
    .out_flip (mode_q.out_flip)
);

// File: tb/sim_crcw_engine.sv
module sim_crcw_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    crcw_engine u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mirror(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] msb_serial(input logic [31:0] c,
                                               input logic [31:0] w,
                                               input logic [31:0] p);
        logic [31:0] x = c;
        for (int i = 31; i >= 0; i--) begin
            logic top;
            top = x[31] ^ w[i];
            x = x << 1;
            if (top) x = x ^ p;
        end
        return x;
    endfunction

    function automatic logic [31:0] lsb_serial(input logic [31:0] c,
                                               input logic [31:0] w,
                                               input logic [31:0] rp);
        logic [31:0] x = c;
        for (int i = 0; i < 32; i++) begin
            logic low;
            low = x[0] ^ w[i];
            x = x >> 1;
            if (low) x = x ^ rp;
        end
        return x;
    endfunction

    function automatic logic [31:0] step_lcg(input logic [31:0] v);
        return v * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
        #1 d = bus_rdata;
        @(posedge clk);
    endtask

    task automatic expect_eq(input string req, input logic [31:0] got,
                             input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, model, seed, poly;
        logic [31:0] polys [2];
        logic [31:0] rpolys [2];
        logic [31:0] burst [5];
        rpolys[0] = 32'hEDB8_8320;
        rpolys[1] = 32'h82F6_3B78;
        polys[0]  = mirror(rpolys[0]);
        polys[1]  = mirror(rpolys[1]);

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R2 reset state
        rd(3'd4, v); expect_eq("R2 seed reset", v, 32'hFFFF_FFFF);
        rd(3'd5, v); expect_eq("R2 poly reset", v, 32'h04C1_1DB7);
        rd(3'd2, v); expect_eq("R2 ctrl reset", v, 32'h0);
        rd(3'd0, v); expect_eq("R2 data reset", v, 32'hFFFF_FFFF);
        idle();
        #1 expect_eq("R1 idle read zero", bus_rdata, 32'h0);

        // R1 unmapped writes ignored, reads zero
        for (int a = 0; a < 8; a++) begin
            if (a == 1 || a == 3 || a == 6 || a == 7) begin
                wr(3'(a), 32'hDEAD_BEEF);
                rd(3'(a), v); expect_eq("R1 unmapped read", v, 32'h0);
            end
        end
        rd(3'd4, v); expect_eq("R1 seed untouched", v, 32'hFFFF_FFFF);
        rd(3'd5, v); expect_eq("R1 poly untouched", v, 32'h04C1_1DB7);
        rd(3'd0, v); expect_eq("R1 data untouched", v, 32'hFFFF_FFFF);

        // R3/R4 control readback: reload bit not stored, other bits zero
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); expect_eq("R4 ctrl shape", v, 32'h0000_00E0);
        wr(3'd2, 32'h0000_0040);
        rd(3'd2, v); expect_eq("R4 ctrl mode 010", v, 32'h0000_0040);

        // R5 R6 R7 R9: every mode, both polynomials, several stream lengths
        for (int pi = 0; pi < 2; pi++) begin
            for (int m = 0; m < 8; m++) begin
                for (int len = 1; len <= 5; len++) begin
                    logic in_rev, out_rev;
                    in_rev  = (m[1:0] == 2'b11);
                    out_rev = m[2];
                    lcg  = step_lcg(lcg);
                    seed = lcg;
                    poly = polys[pi];
                    wr(3'd4, seed);
                    wr(3'd5, poly);
                    wr(3'd2, 32'(m) << 5 | 32'h1);
                    rd(3'd0, v);
                    expect_eq("R9 read after reload", v, out_rev ? mirror(seed) : seed);
                    rd(3'd0, v);
                    expect_eq("R10 read has no side effect", v, out_rev ? mirror(seed) : seed);
                    model = seed;
                    for (int k = 0; k < len; k++) begin
                        lcg = step_lcg(lcg);
                        wr(3'd0, lcg);
                        model = msb_serial(model, in_rev ? mirror(lcg) : lcg, poly);
                        rd(3'd0, v);
                        if (!in_rev && !out_rev)
                            expect_eq("R5 plain fold", v, model);
                        else if (in_rev && !out_rev)
                            expect_eq("R6 input mirror", v, model);
                        else if (m[1:0] != 2'b11)
                            expect_eq("R7 output mirror only", v, mirror(model));
                        else
                            expect_eq("R7 both mirrors", v, mirror(model));
                    end
                end
            end
        end

        // R8 standard reflected checksums against the LSB-first model
        for (int pi = 0; pi < 2; pi++) begin
            wr(3'd4, mirror(32'hFFFF_FFFF));
            wr(3'd5, polys[pi]);
            wr(3'd2, 32'h0000_00E1);
            model = 32'hFFFF_FFFF;
            for (int k = 0; k < 6; k++) begin
                lcg = step_lcg(lcg);
                wr(3'd0, lcg);
                model = lsb_serial(model, lcg, rpolys[pi]);
            end
            rd(3'd0, v);
            expect_eq(pi == 0 ? "R8 CRC-32" : "R8 CRC-32C", v, model);
        end

        // R10 back-to-back burst on consecutive cycles
        wr(3'd4, 32'hA5A5_0F0F);
        wr(3'd5, 32'h04C1_1DB7);
        wr(3'd2, 32'h0000_0001);
        for (int k = 0; k < 5; k++) begin
            lcg = step_lcg(lcg);
            burst[k] = lcg;
        end
        model = 32'hA5A5_0F0F;
        for (int k = 0; k < 5; k++) begin
            wr(3'd0, burst[k]);
            model = msb_serial(model, burst[k], 32'h04C1_1DB7);
        end
        rd(3'd0, v);
        expect_eq("R10 burst", v, model);

        // R3 reload after data restores seed
        wr(3'd2, 32'h0000_0001);
        rd(3'd0, v); expect_eq("R3 reload restores seed", v, 32'hA5A5_0F0F);
        rd(3'd2, v); expect_eq("R3 reload bit reads zero", v, 32'h0);
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule